// File: doc/BRIEF.md
# Atomic Memory Swap Sequencer

This block carries out the memory half of an atomic exchange. When a start strobe is accepted, it reads a byte or a word from one address, writes the store operand back to that same address, and returns the old contents so they can be written to the destination register. The bus stays locked across the read and the write, so no other master can get between them. One internal cycle follows the write. A single-cycle completion pulse then carries the result, an abort indication and a write-back enable.

Before any bus activity, the block screens each request. If any of the three register operand indices names the program counter (the highest index), the request is rejected with an illegal-operand flag. If the condition-passed input is low, the request completes at once without touching memory. In byte mode, the address and the endian mode steer the data to one byte lane. In word mode, all lanes are used and the address is forced to a word boundary.

Top module: `swap_seq`

## Requirements
- R1: With `byte_sel_i`=1 the transfer is one byte; with `byte_sel_i`=0 it is a full 32-bit word.
- R2: For an executed request whose start is sampled at clock edge k, cycle k+1 is a read (`mem_req_o`=1, `mem_we_o`=0). Cycle k+2 is a write (`mem_req_o`=1, `mem_we_o`=1) to the same `mem_addr_o`. Cycle k+3 has no request, and `done_o` is high in cycle k+4.
- R3: In a byte write, `mem_be_o` has exactly one bit set, and bits 7:0 of the store operand appear on that lane of `mem_wdata_o`.
- R4: The byte lane is `addr[1:0]` in little-endian mode (`big_end_i`=0) and `3-addr[1:0]` in big-endian mode. A byte load returns that lane's byte, zero-extended, on `load_data_o`.
- R5: In word mode `mem_be_o`=4'hF, `mem_addr_o` has bits 1:0 cleared, `mem_wdata_o` is the store operand, and `load_data_o` is the full read word.
- R6: `mem_lock_o` is high in the read and write cycles and low in every other cycle.
- R7: An abort on the read, on the write, or on both gives `abort_o`=1 during the done pulse. After a read abort, the write cycle is still issued.
- R8: `wb_valid_o` is high only during a done pulse of an executed request with no abort.
- R9: With `cond_pass_i`=0 there is no bus request. `done_o` rises in cycle k+1, and `abort_o`, `illegal_o` and `wb_valid_o` stay low.
- R10: If any operand index equals 15, there is no bus request, and `done_o` and `illegal_o` are both high in cycle k+1 with `wb_valid_o` low.
- R11: `done_o` lasts exactly one cycle. A start strobe that arrives while a request is in progress is ignored and produces no bus cycle.
- R12: While reset is active, `mem_req_o`, `mem_lock_o`, `done_o`, `abort_o`, `illegal_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| cond_pass_i | input | 1 | Condition passed; low means skip |
| byte_sel_i | input | 1 | 1 byte, 0 word |
| big_end_i | input | 1 | 1 big-endian lane order |
| dst_idx_i | input | 4 | Destination register index |
| src_idx_i | input | 4 | Store operand register index |
| base_idx_i | input | 4 | Address register index |
| addr_i | input | 32 | Swap address |
| store_data_i | input | 32 | Store operand |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write enable |
| mem_be_o | output | 4 | Byte lane enables |
| mem_addr_o | output | 32 | Bus address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_rdata_i | input | 32 | Bus read data, valid in the request cycle |
| mem_abort_i | input | 1 | Bus abort, valid in the request cycle |
| mem_lock_o | output | 1 | Bus lock |
| load_data_o | output | 32 | Old memory value for the destination |
| wb_valid_o | output | 1 | Destination write-back enable |
| done_o | output | 1 | Completion pulse |
| abort_o | output | 1 | Abort seen on read or write |
| illegal_o | output | 1 | Illegal operand rejected |

## Verification
The hardest situation to reach is an abort that lands on only one of the two locked cycles, above all on the write after a clean read. An abort on the write must still suppress write-back, even though the loaded value is good. The bench memory model raises the abort separately on the read phase and on the write phase, under two independent random flags. Directed cases add the read-only, write-only and double-abort combinations. A second start pulse is also injected during the read cycle, to show that the busy block ignores it.

// File: rtl/swap_seq_pkg.sv
package swap_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_INTL  = 3'd3,
    ST_DONE  = 3'd4
  } swp_state_e;
endpackage

// File: rtl/swap_lane_steer.sv
module swap_lane_steer #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic [AW-1:0]    addr,
  input  logic             byte_mode,
  input  logic             big_end,
  input  logic [DW-1:0]    store_data,
  input  logic [DW-1:0]    rdata,
  output logic [DW/8-1:0]  be,
  output logic [DW-1:0]    wdata,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    load_val
);
  localparam int LANES = DW / 8;
  localparam int LSB   = $clog2(LANES);

  function automatic logic [LSB-1:0] lane_pick(input logic [LSB-1:0] lo, input logic big);
    logic [LSB-1:0] top;
    top = LSB'(LANES - 1);
    return big ? (top - lo) : lo;
  endfunction

  logic [LSB-1:0] lane;
  assign lane = lane_pick(addr[LSB-1:0], big_end);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = byte_mode ? (lane == LSB'(g)) : 1'b1;
    assign wdata[g*8 +: 8] = byte_mode ? store_data[7:0] : store_data[g*8 +: 8];
  end

  always_comb begin
    load_val = '0;
    if (byte_mode) load_val[7:0] = rdata[lane*8 +: 8];
    else           load_val      = rdata;
  end

  assign bus_addr = byte_mode ? addr : {addr[AW-1:LSB], {LSB{1'b0}}};
endmodule

// File: rtl/swap_ctrl.sv
module swap_ctrl
  import swap_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       run_ok,
  output swp_state_e state,
  output logic       accept,
  output logic       lock
);
  swp_state_e nxt;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = run_ok ? ST_READ : ST_DONE;
      ST_READ:  nxt = ST_WRITE;
      ST_WRITE: nxt = ST_INTL;
      ST_INTL:  nxt = ST_DONE;
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      lock  <= 1'b0;
    end else begin
      state <= nxt;
      lock  <= (nxt == ST_READ) || (nxt == ST_WRITE);
    end
  end
endmodule

// File: rtl/swap_seq.sv
module swap_seq
  import swap_seq_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int REGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            cond_pass_i,
  input  logic            byte_sel_i,
  input  logic            big_end_i,
  input  logic [REGW-1:0] dst_idx_i,
  input  logic [REGW-1:0] src_idx_i,
  input  logic [REGW-1:0] base_idx_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   store_data_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  input  logic            mem_abort_i,
  output logic            mem_lock_o,
  output logic [DW-1:0]   load_data_o,
  output logic            wb_valid_o,
  output logic            done_o,
  output logic            abort_o,
  output logic            illegal_o
);
  localparam int LANES = DW / 8;
  localparam logic [REGW-1:0] PC_IDX = {REGW{1'b1}};

  function automatic logic names_pc(input logic [REGW-1:0] a, b, c);
    return (a == PC_IDX) || (b == PC_IDX) || (c == PC_IDX);
  endfunction

  swp_state_e state;
  logic accept, lock_q;
  logic req_illegal, run_ok;
  logic rd_cycle, wr_cycle, done_cycle;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, ld_q;
  logic          byte_q, big_q, exec_q, ill_q, ab_rd_q, ab_wr_q;

  logic [LANES-1:0] be_w;
  logic [DW-1:0]    wdata_w, load_w;
  logic [AW-1:0]    baddr_w;

  assign req_illegal = names_pc(dst_idx_i, src_idx_i, base_idx_i);
  assign run_ok      = cond_pass_i && !req_illegal;

  swap_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_i),
    .run_ok (run_ok),
    .state  (state),
    .accept (accept),
    .lock   (lock_q)
  );

  swap_lane_steer #(.DW(DW), .AW(AW)) u_steer (
    .addr       (addr_q),
    .byte_mode  (byte_q),
    .big_end    (big_q),
    .store_data (data_q),
    .rdata      (mem_rdata_i),
    .be         (be_w),
    .wdata      (wdata_w),
    .bus_addr   (baddr_w),
    .load_val   (load_w)
  );

  assign rd_cycle   = (state == ST_READ);
  assign wr_cycle   = (state == ST_WRITE);
  assign done_cycle = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      ld_q    <= '0;
      byte_q  <= 1'b0;
      big_q   <= 1'b0;
      exec_q  <= 1'b0;
      ill_q   <= 1'b0;
      ab_rd_q <= 1'b0;
      ab_wr_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        data_q  <= store_data_i;
        byte_q  <= byte_sel_i;
        big_q   <= big_end_i;
        exec_q  <= run_ok;
        ill_q   <= req_illegal;
        ab_rd_q <= 1'b0;
        ab_wr_q <= 1'b0;
      end
      if (rd_cycle) begin
        ld_q    <= load_w;
        ab_rd_q <= mem_abort_i;
      end
      if (wr_cycle) ab_wr_q <= mem_abort_i;
    end
  end

  assign mem_req_o   = rd_cycle || wr_cycle;
  assign mem_we_o    = wr_cycle;
  assign mem_be_o    = mem_req_o ? be_w : '0;
  assign mem_addr_o  = baddr_w;
  assign mem_wdata_o = wdata_w;
  assign mem_lock_o  = lock_q;

  assign load_data_o = ld_q;
  assign done_o      = done_cycle;
  assign abort_o     = done_cycle && (ab_rd_q || ab_wr_q);
  assign illegal_o   = done_cycle && ill_q;
  assign wb_valid_o  = done_cycle && exec_q && !ab_rd_q && !ab_wr_q;
endmodule

// File: rtl/swap_seq_chk.sv
module swap_seq_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_lock_o,
  input logic [DW/8-1:0] mem_be_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic            done_o,
  input logic            abort_o,
  input logic            illegal_o,
  input logic            wb_valid_o
);
  assert_rd_then_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));

  assert_same_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |=> (mem_addr_o == $past(mem_addr_o)));

  assert_wr_gap_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> ##1 (!mem_req_o && !done_o) ##1 done_o);

  assert_lock_cover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_lock_o);

  assert_lock_only_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock_o |-> mem_req_o);

  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == 1 || mem_be_o == '1));

  assert_wb_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> (done_o && !abort_o && !illegal_o));

  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (done_o && !mem_req_o && !abort_o));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind swap_seq swap_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_lock_o (mem_lock_o),
  .mem_be_o   (mem_be_o),
  .mem_addr_o (mem_addr_o),
  .done_o     (done_o),
  .abort_o    (abort_o),
  .illegal_o  (illegal_o),
  .wb_valid_o (wb_valid_o)
);

// File: tb/swap_seq_tb.sv
module swap_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, cond_pass_i = 1'b0, byte_sel_i = 1'b0, big_end_i = 1'b0;
  logic [3:0]  dst_idx_i = '0, src_idx_i = '0, base_idx_i = '0;
  logic [31:0] addr_i = '0, store_data_i = '0;
  logic        mem_req_o, mem_we_o, mem_lock_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, load_data_o;
  logic        mem_abort_i;
  logic        wb_valid_o, done_o, abort_o, illegal_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  bit ab_rd_en = 0, ab_wr_en = 0;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  swap_seq u_dut (.*);

  assign mem_rdata_i = mem[mem_addr_o[5:2]];
  assign mem_abort_i = mem_req_o && (mem_we_o ? ab_wr_en : ab_rd_en);

  always @(posedge clk)
    if (mem_req_o && mem_we_o && !mem_abort_i)
      for (int i = 0; i < 4; i++)
        if (mem_be_o[i]) mem[mem_addr_o[5:2]][i*8 +: 8] <= mem_wdata_o[i*8 +: 8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lane_f(input logic [31:0] a, input bit big);
    return big ? 3 - int'(a[1:0]) : int'(a[1:0]);
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] old, input logic [31:0] a, input bit bsel, input bit big);
    if (!bsel) return old;
    return {24'h0, old[lane_f(a, big)*8 +: 8]};
  endfunction

  function automatic logic [31:0] exp_store(input logic [31:0] old, input logic [31:0] a, input logic [31:0] d, input bit bsel, input bit big);
    logic [31:0] r;
    if (!bsel) return d;
    r = old;
    r[lane_f(a, big)*8 +: 8] = d[7:0];
    return r;
  endfunction

  task automatic run_op(input bit bsel, input bit big, input bit cond, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] ri, input bit abr, input bit abw,
                        input bit busy_poke);
    logic [31:0] old, eaddr, mask, nw;
    bit ill, abt;
    ill   = (ri == 4'hF);
    old   = mem[a[5:2]];
    eaddr = bsel ? a : {a[31:2], 2'b00};
    @(negedge clk);
    start_i = 1; cond_pass_i = cond; byte_sel_i = bsel; big_end_i = big;
    dst_idx_i = ri; src_idx_i = 4'd1; base_idx_i = 4'd2; addr_i = a; store_data_i = d;
    ab_rd_en = abr; ab_wr_en = abw;
    @(negedge clk);
    start_i = 0;
    if (ill || !cond) begin
      chk(done_o === 1'b1, ill ? "R10 done" : "R9 done", 32'(done_o), 1);
      chk(mem_req_o === 1'b0, ill ? "R10 noreq" : "R9 noreq", 32'(mem_req_o), 0);
      chk(illegal_o === ill, "R10 illegal flag", 32'(illegal_o), 32'(ill));
      chk(wb_valid_o === 1'b0 && abort_o === 1'b0, "R9 wb/abort low", {30'h0, wb_valid_o, abort_o}, 0);
      @(negedge clk);
      chk(done_o === 1'b0, "R11 single pulse", 32'(done_o), 0);
      chk(mem[a[5:2]] === old, "R9 memory unchanged", mem[a[5:2]], old);
      return;
    end
    chk(mem_req_o === 1 && mem_we_o === 0, "R2 read cycle", {30'h0, mem_req_o, mem_we_o}, 2);
    chk(mem_lock_o === 1, "R6 lock in read", 32'(mem_lock_o), 1);
    chk(mem_addr_o === eaddr, "R5 read address", mem_addr_o, eaddr);
    if (busy_poke) start_i = 1;
    @(negedge clk);
    start_i = 0;
    mask = {{8{mem_be_o[3]}}, {8{mem_be_o[2]}}, {8{mem_be_o[1]}}, {8{mem_be_o[0]}}};
    nw   = exp_store(32'h0, a, d, bsel, big);
    chk(mem_req_o === 1 && mem_we_o === 1, "R7 R2 write cycle", {30'h0, mem_req_o, mem_we_o}, 3);
    chk(mem_lock_o === 1, "R6 lock in write", 32'(mem_lock_o), 1);
    chk(mem_addr_o === eaddr, "R2 write same address", mem_addr_o, eaddr);
    if (bsel) begin
      chk(mem_be_o === 4'(1 << lane_f(a, big)), "R4 R3 byte lane", 32'(mem_be_o), 32'(1 << lane_f(a, big)));
      chk((mem_wdata_o & mask) === nw, "R3 byte data", mem_wdata_o & mask, nw);
    end else begin
      chk(mem_be_o === 4'hF, "R5 R1 word lanes", 32'(mem_be_o), 32'hF);
      chk(mem_wdata_o === d, "R5 word data", mem_wdata_o, d);
    end
    @(negedge clk);
    chk(mem_req_o === 0 && mem_lock_o === 0 && done_o === 0, "R2 R6 internal cycle",
        {29'h0, mem_req_o, mem_lock_o, done_o}, 0);
    @(negedge clk);
    abt = abr || abw;
    chk(done_o === 1, "R2 done timing", 32'(done_o), 1);
    chk(abort_o === abt, "R7 abort flag", 32'(abort_o), 32'(abt));
    chk(wb_valid_o === !abt, "R8 writeback", 32'(wb_valid_o), 32'(!abt));
    if (!abr) chk(load_data_o === exp_load(old, a, bsel, big), "R4 R1 load data",
                  load_data_o, exp_load(old, a, bsel, big));
    @(negedge clk);
    chk(done_o === 0, "R11 done one cycle", 32'(done_o), 0);
    chk(mem_req_o === 0, "R11 busy start ignored", 32'(mem_req_o), 0);
    nw = abw ? old : exp_store(old, a, d, bsel, big);
    chk(mem[a[5:2]] === nw, "R1 memory after swap", mem[a[5:2]], nw);
    ab_rd_en = 0; ab_wr_en = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA0B1C2D3 ^ (i * 32'h01010101);
    repeat (3) @(negedge clk);
    chk(mem_req_o === 0 && mem_lock_o === 0 && done_o === 0 && abort_o === 0 &&
        illegal_o === 0 && wb_valid_o === 0, "R12 reset outputs", 32'(mem_req_o), 0);
    rst_n = 1;
    @(negedge clk);
    run_op(0, 0, 1, 32'h14, 32'hDEADBEEF, 4'd0, 0, 0, 0);
    run_op(1, 0, 1, 32'h21, 32'h000000AB, 4'd3, 0, 0, 0);
    run_op(1, 1, 1, 32'h21, 32'h0000005C, 4'd3, 0, 0, 0);
    run_op(1, 1, 1, 32'h0F, 32'h12345677, 4'd3, 0, 0, 1);
    run_op(0, 1, 1, 32'h2B, 32'hCAFEF00D, 4'd4, 0, 0, 0);
    run_op(1, 0, 1, 32'h30, 32'h11, 4'd5, 1, 0, 0);
    run_op(1, 0, 1, 32'h31, 32'h22, 4'd5, 0, 1, 0);
    run_op(0, 0, 1, 32'h34, 32'h33, 4'd5, 1, 1, 0);
    run_op(0, 0, 0, 32'h38, 32'h44, 4'd6, 0, 0, 0);
    run_op(0, 0, 1, 32'h3C, 32'h55, 4'hF, 0, 0, 0);
    void'($urandom(32'h5EED));
    for (int k = 0; k < 300; k++) begin
      run_op($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 9) != 0,
             $urandom_range(0, 63), $urandom,
             ($urandom_range(0, 19) == 0) ? 4'hF : 4'($urandom_range(0, 14)),
             $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 4) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule